// File: doc/BRIEF.md
# Firmware Bus Target Frame and Select Front-End

This block sits at the pin edge of a flash-style target on a four-bit multiplexed firmware bus. On each rising clock edge it samples an active-low frame strobe and a data nibble. From these it tracks whether a bus operation is idle, in flight or cut short. It decides whether this device is the one being addressed by comparing received bits with strapped identity inputs. It also drives a one-nibble acknowledgement back when a frame that selected it has finished. Two active-low reset inputs are merged into one internal reset. An interface-mode strap is captured only while that reset is held, and the data bus is released while reset is active.

The frame format handled here is a simplified fixed sequence. The first nibble is the start nibble, sampled with the strobe low. Then comes one header nibble: the device identity in hub mode, or a cycle type in the low-pin-count (LPC) mode. After it come the address nibbles, most significant first: seven nibbles (28 bits) in hub mode and eight nibbles (32 bits) in LPC mode. The start nibble picks the mode: 4'hD is hub mode and 4'h0 is LPC mode. Downstream logic receives a start pulse, an abort pulse, a select flag and a busy flag. All of these are plain control pins. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `fwb_target_front`

## Requirements
- R1: Every rising edge that samples `frame_n` low, while the block is not in parallel mode, gives a one-cycle `start_pulse` in the following cycle. This holds whatever the value of the start nibble.
- R2: If `frame_n` is sampled low while an operation is in progress, `abort_pulse` rises together with `start_pulse`. An operation is in progress once at least one nibble after the start has been consumed, or while the acknowledgement is being driven. The same low sample begins a new frame. A repeated low right after a start gives no abort.
- R3: `busy` is high from the cycle after a recognised start nibble (4'hD or 4'h0) until the frame ends. A frame ends with the acknowledgement, with a selection miss, or with a new start. While `frame_n` stays high and no frame is active, `busy` stays low.
- R4: In hub mode (start 4'hD), the header nibble is compared with all four bits of `id_strap`, with equal bits meaning a match. `sel` shows the result in the cycle after that nibble.
- R5: In LPC mode (start 4'h0), the frame carries a 32-bit address. Address bits 21:19 are taken from the low two bits of the third address nibble and the top bit of the fourth. Each of these bits matches when it equals the inverse of `id_strap[2:0]`. `id_strap[3]` has no effect. `sel` shows the result in the cycle after the fourth address nibble.
- R6: When selection misses, `sel` stays low and `busy` falls in the same cycle the miss is seen. The rest of the frame is ignored and `lad_oe` never rises. The next low strobe starts a new frame without an abort.
- R7: The internal reset is active while either `rst_a_n` or `rst_b_n` is low. It clears `busy`, `sel`, `start_pulse` and `abort_pulse`, and forces `lad_oe` low at once, without waiting for a clock. After reset the block is idle.
- R8: `if_strap` is sampled only on clock edges during reset, and the value is shown on `parallel_mode`. A high value puts the block in parallel mode, where frames are ignored: no `start_pulse` and no `busy`. Changes to `if_strap` outside reset have no effect.
- R9: After the last address nibble of a selected frame, `lad_oe` is high for exactly one cycle with `lad_o` equal to 4'h0. Then `busy` falls.
- R10: A start nibble other than 4'hD or 4'h0 leaves `busy` low, and the frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_a_n | input | 1 | Interface reset, active low |
| rst_b_n | input | 1 | Processor reset, active low |
| if_strap | input | 1 | Interface-mode strap, high selects parallel mode |
| id_strap | input | 4 | Device identity straps |
| frame_n | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | Nibble received from the bus |
| lad_o | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Output enable for `lad_o` (low means high impedance) |
| start_pulse | output | 1 | One-cycle pulse after a sampled frame start |
| abort_pulse | output | 1 | One-cycle pulse when a frame in progress is cut short |
| sel | output | 1 | Device is addressed by the current frame |
| busy | output | 1 | A recognised frame is in progress |
| parallel_mode | output | 1 | Latched interface-mode strap |

## Verification
Hub and LPC frames are sent with headers and addresses that either match the straps or are random. This separates the direct four-bit compare from the inverted three-bit compare and shows that `id_strap[3]` matters only in hub mode. Frames are cut at random nibble positions, including right after the start and during the acknowledgement. This separates a real abort from a repeated start. Unknown start nibbles, resets held on either input alone with the acknowledgement active, and strap changes inside and outside reset show the ignore, tri-state and latch rules.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_RESP = 2'd2
  } phase_t;
endpackage

// File: rtl/fwb_reset_strap.sv
module fwb_reset_strap (
  input  logic clk,
  input  logic rst_a_n,
  input  logic rst_b_n,
  input  logic if_strap,
  output logic rst_n,
  output logic parallel_q
);
  // either source holds the block in reset
  assign rst_n = rst_a_n & rst_b_n;

  // strap is only observed while reset is asserted
  always_ff @(posedge clk) begin
    if (!rst_n) parallel_q <= if_strap;
  end

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(parallel_q)); // R8
endmodule

// File: rtl/fwb_id_match.sv
module fwb_id_match #(
  parameter int ID_W     = 4,
  parameter int LPC_ID_W = 3
) (
  input  logic [ID_W-1:0]       id_strap,
  input  logic [ID_W-1:0]       nib,
  input  logic [LPC_ID_W-2:0]   hold,
  output logic                  hub_hit,
  output logic                  lpc_hit
);
  logic [LPC_ID_W-1:0] field;
  logic [LPC_ID_W-1:0] bit_ok;

  // upper field bits arrived with the earlier nibble, lowest with this one
  assign field = {hold, nib[ID_W-1]};

  genvar i;
  generate
    for (i = 0; i < LPC_ID_W; i++) begin : g_lpc_bit
      assign bit_ok[i] = (field[i] == ~id_strap[i]);
    end
  endgenerate

  assign lpc_hit = &bit_ok;
  assign hub_hit = (nib == id_strap);
endmodule

// File: rtl/fwb_frame_ctl.sv
module fwb_frame_ctl
  import fwb_pkg::*;
#(
  parameter int          LPC_ID_W      = 3,
  parameter logic [3:0]  START_LPC     = 4'h0,
  parameter logic [3:0]  START_HUB     = 4'hD,
  parameter int          LPC_ADDR_NIBS = 8,
  parameter int          HUB_ADDR_NIBS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               frame_n,
  input  logic [NIB_W-1:0]   lad_i,
  input  logic               hub_hit,
  input  logic               lpc_hit,
  output logic [LPC_ID_W-2:0] hold_q,
  output phase_t             phase,
  output logic               sel_q,
  output logic               start_q,
  output logic               abort_q
);
  localparam int CNT_W = $clog2(LPC_ADDR_NIBS + 2);
  // bits 21:19 straddle the nibbles holding 23:20 and 19:16
  localparam logic [CNT_W-1:0] K_HI     = CNT_W'(LPC_ADDR_NIBS - 5);
  localparam logic [CNT_W-1:0] K_LO     = CNT_W'(LPC_ADDR_NIBS - 4);
  localparam logic [CNT_W-1:0] LAST_LPC = CNT_W'(LPC_ADDR_NIBS);
  localparam logic [CNT_W-1:0] LAST_HUB = CNT_W'(HUB_ADDR_NIBS);

  logic [CNT_W-1:0] cnt;
  logic             hub_q;
  logic             in_prog;
  logic [CNT_W-1:0] last_k;

  assign in_prog = ((phase == PH_RUN) && (cnt != '0)) || (phase == PH_RESP);
  assign last_k  = hub_q ? LAST_HUB : LAST_LPC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      hub_q   <= 1'b0;
      sel_q   <= 1'b0;
      hold_q  <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      if (enable && !frame_n) begin
        start_q <= 1'b1;
        abort_q <= in_prog;
        sel_q   <= 1'b0;
        cnt     <= '0;
        hub_q   <= (lad_i == START_HUB);
        phase   <= ((lad_i == START_HUB) || (lad_i == START_LPC)) ? PH_RUN : PH_IDLE;
      end else begin
        case (phase)
          PH_RUN: begin
            cnt <= cnt + 1'b1;
            if (cnt == last_k) phase <= PH_RESP;
            if (hub_q && (cnt == '0)) begin
              if (hub_hit) sel_q <= 1'b1;
              else         phase <= PH_IDLE;
            end
            if (!hub_q && (cnt == K_HI)) hold_q <= lad_i[LPC_ID_W-2:0];
            if (!hub_q && (cnt == K_LO)) begin
              if (lpc_hit) sel_q <= 1'b1;
              else         phase <= PH_IDLE;
            end
          end
          PH_RESP: begin
            phase <= PH_IDLE;
            sel_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_START_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(!frame_n)); // R1
  AST_ABORT_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> ($past(phase) != PH_IDLE)); // R2
  AST_SEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> (phase != PH_IDLE)); // R6
  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RESP) |=> (phase != PH_RESP)); // R9
endmodule

// File: rtl/fwb_target_front.sv
module fwb_target_front
  import fwb_pkg::*;
#(
  parameter int          ID_W          = 4,
  parameter int          LPC_ID_W      = 3,
  parameter logic [3:0]  START_LPC     = 4'h0,
  parameter logic [3:0]  START_HUB     = 4'hD,
  parameter int          LPC_ADDR_NIBS = 8,
  parameter int          HUB_ADDR_NIBS = 7,
  parameter logic [3:0]  RESP_NIBBLE   = 4'h0
) (
  input  logic            clk,
  input  logic            rst_a_n,
  input  logic            rst_b_n,
  input  logic            if_strap,
  input  logic [ID_W-1:0] id_strap,
  input  logic            frame_n,
  input  logic [3:0]      lad_i,
  output logic [3:0]      lad_o,
  output logic            lad_oe,
  output logic            start_pulse,
  output logic            abort_pulse,
  output logic            sel,
  output logic            busy,
  output logic            parallel_mode
);
  logic                rst_n;
  logic                hub_hit;
  logic                lpc_hit;
  logic [LPC_ID_W-2:0] hold_q;
  phase_t              phase;

  fwb_reset_strap u_rst (
    .clk       (clk),
    .rst_a_n   (rst_a_n),
    .rst_b_n   (rst_b_n),
    .if_strap  (if_strap),
    .rst_n     (rst_n),
    .parallel_q(parallel_mode)
  );

  fwb_id_match #(.ID_W(ID_W), .LPC_ID_W(LPC_ID_W)) u_match (
    .id_strap(id_strap),
    .nib     (lad_i),
    .hold    (hold_q),
    .hub_hit (hub_hit),
    .lpc_hit (lpc_hit)
  );

  fwb_frame_ctl #(
    .LPC_ID_W     (LPC_ID_W),
    .START_LPC    (START_LPC),
    .START_HUB    (START_HUB),
    .LPC_ADDR_NIBS(LPC_ADDR_NIBS),
    .HUB_ADDR_NIBS(HUB_ADDR_NIBS)
  ) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (!parallel_mode),
    .frame_n(frame_n),
    .lad_i  (lad_i),
    .hub_hit(hub_hit),
    .lpc_hit(lpc_hit),
    .hold_q (hold_q),
    .phase  (phase),
    .sel_q  (sel),
    .start_q(start_pulse),
    .abort_q(abort_pulse)
  );

  assign busy   = (phase != PH_IDLE);
  // reset gates the driver directly so release needs no clock
  assign lad_oe = rst_n & (phase == PH_RESP) & sel;
  assign lad_o  = lad_oe ? RESP_NIBBLE : 4'h0;

  AST_TRISTATE_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !lad_oe); // R7
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    lad_oe |-> (sel && busy)); // R9
endmodule

// File: tb/fwb_target_front_test.sv
module fwb_target_front_test;
  logic       clk = 1'b0;
  logic       rst_a_n, rst_b_n, if_strap, frame_n;
  logic [3:0] id_strap, lad_i, lad_o;
  logic       lad_oe, start_pulse, abort_pulse, sel, busy, parallel_mode;

  int checks = 0;
  int fails  = 0;
  bit exp_prog = 1'b0;

  always #10 clk = ~clk;

  fwb_target_front uut (
    .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .if_strap(if_strap),
    .id_strap(id_strap), .frame_n(frame_n), .lad_i(lad_i), .lad_o(lad_o),
    .lad_oe(lad_oe), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
    .sel(sel), .busy(busy), .parallel_mode(parallel_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic tick(input logic f, input logic [3:0] n);
    frame_n = f;
    lad_i   = n;
    @(posedge clk);
    #10;
  endtask

  function automatic bit exp_select(input bit hub, input logic [3:0] hdr, input logic [31:0] addr);
    if (hub) return hdr == id_strap;
    return addr[21:19] == ~id_strap[2:0];
  endfunction

  task automatic run_frame(input logic [3:0] st, input logic [3:0] hdr,
                           input logic [31:0] addr, input int cut);
    bit hub   = (st == 4'hD);
    bit valid = hub || (st == 4'h0);
    int last  = hub ? 7 : 8;
    int selk  = hub ? 0 : 4;
    bit es    = exp_select(hub, hdr, addr);
    logic [3:0] nib;
    tick(1'b0, st);
    check("R1 start", start_pulse, 1);
    check("R2 abort", abort_pulse, exp_prog);
    check(valid ? "R3 busy" : "R10 busy", busy, valid);
    check("R4 sel clear", sel, 0);
    exp_prog = 1'b0;
    if (!valid) return;
    for (int k = 0; k <= last; k++) begin
      if (k == cut) return;
      if (k == 0) nib = hdr;
      else if (hub) nib = addr[27-4*(k-1) -: 4];
      else nib = addr[31-4*(k-1) -: 4];
      tick(1'b1, nib);
      exp_prog = 1'b1;
      if (k == selk) begin
        check(hub ? "R4 sel" : "R5 sel", sel, es);
        if (!es) begin
          check("R6 busy", busy, 0);
          check("R6 oe", lad_oe, 0);
          exp_prog = 1'b0;
          return;
        end
      end
      check("R3 busy", busy, 1);
      check("R1 pulse width", start_pulse, 0);
    end
    check("R9 oe", lad_oe, 1);
    check("R9 nibble", lad_o, 4'h0);
    if (cut == last + 1) return;
    tick(1'b1, 4'($urandom));
    check("R9 oe drop", lad_oe, 0);
    check("R9 busy drop", busy, 0);
    exp_prog = 1'b0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_a_n = 0; rst_b_n = 0; if_strap = 0; id_strap = 4'b0101;
    frame_n = 1; lad_i = 0;
    repeat (3) @(posedge clk);
    #10;
    check("R7 reset busy", busy, 0);
    check("R7 reset oe", lad_oe, 0);
    check("R7 reset start", start_pulse, 0);
    check("R8 strap low", parallel_mode, 0);
    rst_a_n = 1; rst_b_n = 1;
    tick(1'b1, 4'h0);
    check("R3 idle", busy, 0);

    // directed hub and lpc frames
    run_frame(4'hD, 4'b0101, 32'h0, 99);
    run_frame(4'hD, 4'b1101, 32'h0, 99);
    run_frame(4'h0, 4'h2, 32'h0010_0000, 99);  // bits 21:19 = 010
    id_strap = 4'b1101;                         // R5: bit 3 changed, same select
    run_frame(4'h0, 4'h2, 32'h0010_0000, 99);
    run_frame(4'h0, 4'h2, 32'h0018_0000, 99);  // miss
    tick(1'b1, 4'h0);
    check("R6 idle after miss", busy, 0);
    run_frame(4'h5, 4'h0, 32'h0, 99);           // R10
    tick(1'b1, 4'h0);
    check("R10 ignored", busy, 0);
    // abort mid frame, then repeated start
    run_frame(4'hD, 4'b1101, 32'h0, 3);
    run_frame(4'h0, 4'h2, 32'h0010_0000, 0);
    run_frame(4'h0, 4'h2, 32'h0010_0000, 9);    // stop during acknowledgement
    run_frame(4'hD, 4'b1101, 32'h0, 99);        // abort out of acknowledgement

    // reset during acknowledgement, one input at a time
    run_frame(4'h0, 4'h2, 32'h0010_0000, 9);
    #2 rst_b_n = 0;
    #1;
    check("R7 async oe", lad_oe, 0);
    check("R7 async busy", busy, 0);
    if_strap = 1;
    @(posedge clk); #10;
    rst_b_n = 1; exp_prog = 0;
    check("R8 latched", parallel_mode, 1);
    if_strap = 0;
    tick(1'b0, 4'h0);
    check("R8 no start", start_pulse, 0);
    check("R8 no busy", busy, 0);
    tick(1'b1, 4'h2);
    check("R8 strap ignored", parallel_mode, 1);
    rst_a_n = 0;
    @(posedge clk); #10;
    rst_a_n = 1;
    check("R8 relatched", parallel_mode, 0);

    // random frames
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  st, hdr;
      logic [31:0] addr;
      int cut, pick;
      if (n % 50 == 0) id_strap = 4'($urandom);
      pick = $urandom_range(0, 9);
      st   = (pick < 5) ? 4'hD : (pick < 9) ? 4'h0 : 4'($urandom);
      hdr  = ($urandom_range(0, 1) == 1) ? id_strap : 4'($urandom);
      addr = $urandom;
      if ($urandom_range(0, 1) == 1) addr[21:19] = ~id_strap[2:0];
      cut  = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 9) : 99;
      run_frame(st, hdr, addr, cut);
      if (cut == 99 && $urandom_range(0, 1) == 1 && !exp_prog) begin
        tick(1'b1, 4'($urandom));
        check("R3 idle high", busy, 0);
      end
    end
    finish_up();
  end
endmodule